// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Accumulator

This block performs 32-bit integer multiplication and division for a processor datapath. Results land in a 64-bit accumulator, kept as two 32-bit halves: a high word and a low word. Both halves are always visible on the outputs. The requester presents an opcode and two operands with a one-cycle start strobe.

Multiplies finish on the clock edge that accepts them. A product can replace the accumulator, or it can be added to or subtracted from the concatenated high:low value. Each of these forms comes in a signed variant and an unsigned variant.

A divide runs an iterative restoring algorithm that produces one quotient bit per cycle, followed by a sign-correction cycle. The busy output is high for the whole run. A start request that arrives while the block is busy is dropped.

Top module: `hilo_muldiv`

## Requirements
- R1: Asserting rst_ni low clears hi_o, lo_o and busy_o, including in the middle of a divide.
- R2: Opcode 0 (signed multiply) writes the 64-bit product of the two sign-interpreted operands, upper half to hi_o and lower half to lo_o. The result is visible after the accepting edge.
- R3: Opcode 1 (unsigned multiply) writes the 64-bit product of the zero-extended operands, split the same way as R2.
- R4: Opcodes 2 (signed) and 3 (unsigned) add the product to {hi_o,lo_o} modulo 2^64.
- R5: Opcodes 4 (signed) and 5 (unsigned) subtract the product from {hi_o,lo_o} modulo 2^64.
- R6: Opcodes 6 (signed) and 7 (unsigned) divide a_i by b_i. The quotient is truncated toward zero and goes to lo_o. The remainder goes to hi_o and takes the sign of the dividend.
- R7: A divide with b_i equal to zero leaves hi_o and lo_o unchanged and does not raise busy_o.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF gives lo_o = 0x80000000 and hi_o = 0.
- R9: An accepted divide holds busy_o high for exactly 33 cycles. The result appears in the same cycle that busy_o falls.
- R10: A start request while busy_o is high is ignored. It does not change the divide result or the divide length.
- R11: Multiply opcodes never raise busy_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when busy_o is low |
| op_i | input | 3 | Operation code (0..7, see R2 to R6) |
| a_i | input | 32 | First operand / dividend |
| b_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Divide in progress |
| hi_o | output | 32 | Upper accumulator word / remainder |
| lo_o | output | 32 | Lower accumulator word / quotient |

## Verification
Two situations are hard to reach from the ports. The first is a start strobe that arrives in the middle of a divide. The bench pulses a multiply request several cycles into a running divide, then confirms that the divide still takes 33 cycles and that its result is unaltered. The second is a reset that lands while the iteration counter is partway through a run. The bench drops rst_ni mid-divide and checks that every output returns to zero. The most negative dividend over -1 and a zero divisor are driven from the vector table. Each follows a state the accumulator already holds, so an unwanted write would show.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_MADD_S = 3'd2,
    OP_MADD_U = 3'd3,
    OP_MSUB_S = 3'd4,
    OP_MSUB_U = 3'd5,
    OP_DIV_S  = 3'd6,
    OP_DIV_U  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ACC_SET,
    ACC_ADD,
    ACC_SUB
  } acc_mode_e;

  function automatic logic op_is_signed(logic [2:0] op);
    return ~op[0];
  endfunction

  function automatic logic op_is_div(logic [2:0] op);
    return op[2] & op[1];
  endfunction

  function automatic acc_mode_e op_acc_mode(logic [2:0] op);
    case (op[2:1])
      2'b01:   return ACC_ADD;
      2'b10:   return ACC_SUB;
      default: return ACC_SET;
    endcase
  endfunction
endpackage

// File: rtl/hilo_mul.sv
module hilo_mul
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             signed_i,
  input  acc_mode_e        mode_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [2*W-1:0]   acc_i,
  output logic [2*W-1:0]   res_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext, b_ext, prod;

  // product of extended operands modulo 2^PW is exact for both signednesses
  assign a_ext = {{W{signed_i & a_i[W-1]}}, a_i};
  assign b_ext = {{W{signed_i & b_i[W-1]}}, b_i};
  assign prod  = a_ext * b_ext;

  always_comb begin
    case (mode_i)
      ACC_ADD: res_o = acc_i + prod;
      ACC_SUB: res_o = acc_i - prod;
      default: res_o = prod;
    endcase
  end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dsr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;

  state_e        state_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic          neg_quo_q, neg_rem_q;

  logic          dvd_neg, dsr_neg;
  logic [W-1:0]  dvd_mag, dsr_mag;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign dvd_neg = signed_i & dvd_i[W-1];
  assign dsr_neg = signed_i & dsr_i[W-1];
  assign dvd_mag = dvd_neg ? -dvd_i : dvd_i;
  assign dsr_mag = dsr_neg ? -dsr_i : dsr_i;

  // one restoring step: bring down next dividend bit, try subtract
  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dsr_q};
  assign fits    = ~diff[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dsr_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_RUN;
          cnt_q     <= '0;
          rem_q     <= '0;
          quo_q     <= dvd_mag;
          dsr_q     <= dsr_mag;
          neg_quo_q <= dvd_neg ^ dsr_neg;
          neg_rem_q <= dvd_neg;
        end
        ST_RUN: begin
          rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], fits};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIX);
  assign quo_o  = neg_quo_q ? -quo_q : quo_q;
  assign rem_o  = neg_rem_q ? -rem_q : rem_q;
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0]   hi_q, lo_q;
  logic [2*W-1:0] mul_res;
  logic           accept, is_div, div_go, div_busy, div_done;
  logic [W-1:0]   div_quo, div_rem;

  assign accept = start_i & ~div_busy;
  assign is_div = op_is_div(op_i);
  assign div_go = accept & is_div & (b_i != '0);

  hilo_mul #(.W(W)) u_mul (
    .signed_i (op_is_signed(op_i)),
    .mode_i   (op_acc_mode(op_i)),
    .a_i      (a_i),
    .b_i      (b_i),
    .acc_i    ({hi_q, lo_q}),
    .res_o    (mul_res)
  );

  hilo_div #(.W(W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (div_go),
    .signed_i (op_is_signed(op_i)),
    .dvd_i    (a_i),
    .dsr_i    (b_i),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .quo_o    (div_quo),
    .rem_o    (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (div_done) begin
      hi_q <= div_rem;
      lo_q <= div_quo;
    end else if (accept && !is_div) begin
      {hi_q, lo_q} <= mul_res;
    end
  end

  assign busy_o = div_busy;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         busy_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int LW = $clog2(W + 2) + 1;
  localparam logic [LW-1:0] RUN_LEN = LW'(W + 1);

  logic [2*W-1:0] za, zb, sa, sb;
  logic [LW-1:0]  busy_cnt_q;
  logic           take;

  assign za   = {{W{1'b0}}, a_i};
  assign zb   = {{W{1'b0}}, b_i};
  assign sa   = {{W{a_i[W-1]}}, a_i};
  assign sb   = {{W{b_i[W-1]}}, b_i};
  assign take = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else         busy_cnt_q <= busy_o ? busy_cnt_q + 1'b1 : '0;
  end

  p_mul_signed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_MUL_S) |=> ({hi_o, lo_o} == $past(sa * sb)));

  p_mul_unsigned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_MUL_U) |=> ({hi_o, lo_o} == $past(za * zb)));

  p_zero_div_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_is_div(op_i) && b_i == '0) |=> (!busy_o && $stable(hi_o) && $stable(lo_o)));

  p_div_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt_q == RUN_LEN));

  p_div_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || ($stable(hi_o) && $stable(lo_o))));

  p_mul_no_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !op_is_div(op_i)) |=> !busy_o);
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .busy_o (busy_o),
  .hi_o   (hi_o),
  .lo_o   (lo_o)
);

// File: tb/hilo_muldiv_test.sv
`timescale 1ns/1ps
module hilo_muldiv_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        busy_o;
  logic [31:0] hi_o, lo_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  always #2.5 clk = ~clk;

  hilo_muldiv uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  // op, a, b
  localparam logic [66:0] VEC [12] = '{
    {3'd0, 32'd7,        32'hFFFF_FFFD},
    {3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd2, 32'hFFFF_FFFB, 32'd6},
    {3'd3, 32'h8000_0000, 32'd4},
    {3'd4, 32'd3,        32'd3},
    {3'd5, 32'h0000_FFFF, 32'h0001_0000},
    {3'd6, 32'hFFFF_FFF9, 32'd2},
    {3'd6, 32'd7,        32'hFFFF_FFFE},
    {3'd7, 32'hFFFF_FFFF, 32'd16},
    {3'd6, 32'h8000_0000, 32'hFFFF_FFFF},
    {3'd6, 32'd100,      32'd0},
    {3'd7, 32'd5,        32'd9}
  };

  function automatic string tag_of(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    if (op >= 3'd6 && b == 0) return "R7";
    if (op == 3'd6 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R8";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act_h, logic [31:0] act_l,
                       logic [31:0] exp_h, logic [31:0] exp_l);
    n_chk++;
    if (act_h !== exp_h || act_l !== exp_l) begin
      n_bad++;
      $display("FAIL %s: hi=%h lo=%h expected hi=%h lo=%h", tag, act_h, act_l, exp_h, exp_l);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent reference from the requirement text
  task automatic model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p, acc;
    sa = op[0] ? longint'({32'b0, a}) : longint'($signed(a));
    sb = op[0] ? longint'({32'b0, b}) : longint'($signed(b));
    acc = {m_hi, m_lo};
    if (op >= 3'd6) begin
      if (b != 0) begin
        q = sa / sb;
        r = sa % sb;
        m_lo = q[31:0];
        m_hi = r[31:0];
      end
    end else begin
      p = 64'(sa * sb);
      if (op[2:1] == 2'b01) acc = acc + p;
      else if (op[2:1] == 2'b10) acc = acc - p;
      else acc = p;
      {m_hi, m_lo} = acc;
    end
  endtask

  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_vec(logic [2:0] op, logic [31:0] a, logic [31:0] b, bit intrude);
    string tag;
    int cyc;
    tag = tag_of(op, a, b);
    issue(op, a, b);
    model(op, a, b);
    cyc = 0;
    while (busy_o && cyc < 100) begin
      cyc++;
      if (intrude && cyc == 5) begin
        start_i = 1'b1; op_i = 3'd1; a_i = 32'd3; b_i = 32'd3;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    if (op >= 3'd6 && b != 0) check_int(intrude ? "R10 length" : "R9 busy length", cyc, 33);
    else check_int(op >= 3'd6 ? "R7 busy" : "R11 busy", cyc, 0);
    check(intrude ? "R10" : tag, hi_o, lo_o, m_hi, m_lo);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", hi_o, lo_o, 32'd0, 32'd0);
    check_int("R1 busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0], 1'b0);

    // R10: strobe in the middle of a divide
    run_vec(3'd7, 32'd1000, 32'd7, 1'b1);
    // R4/R5 on a known base after divide
    run_vec(3'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    run_vec(3'd5, 32'hFFFF_FFFF, 32'd2, 1'b0);

    // R1: reset in the middle of a divide
    issue(3'd6, 32'h1234_5678, 32'd3);
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    m_hi = '0; m_lo = '0;
    @(negedge clk);
    check("R1 mid-run", hi_o, lo_o, 32'd0, 32'd0);
    check_int("R1 mid-run busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run_vec(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule